// File: doc/BRIEF.md
# Load/Store Bus Cycle Sequencer

This block plays out, one bus cycle per clock, the memory traffic of an 8-bit accumulator load or store once the opcode has been decoded elsewhere. The caller supplies the instruction address, a three-bit addressing-mode code, a store flag, both index registers and the byte to store. The block fetches the operand bytes and any zero-page pointer bytes over the bus. It then drives the exact address and read/write strobe sequence of the real instruction. That sequence includes the dummy reads an indexed mode spends while it fixes a carry into the high byte.

Loads take a shortcut. When adding the index does not carry, the read at the summed address is the last cycle. When it does carry, that read is thrown away and repeated at the corrected address. Stores never take that shortcut: they always read the uncorrected address first and then write the corrected one, so no write ever reaches a wrong location. Zero-page arithmetic wraps inside page zero.

A `done` output is high in the final bus cycle of an instruction and while the block is idle. A `start` seen with `done` high begins the next instruction in the following cycle, so instructions can run back to back with no gap.

Top module: `lsseq_top`

## Requirements
- R1: While reset is held and after it is released, the block is idle with `done`=1, `bus_rw`=1 (read), `bus_addr`=0 and `ld_valid`=0.
- R2: An instruction starts only when `start` and `done` are both high at a clock edge. Its first bus cycle is a read at `pc`. Mode, store flag, index registers, `pc` and store data are latched at that edge, so later changes to them, and `start` pulses while busy, leave the cycle trace unchanged. Mode codes: 0 zero page, 1 zero page+X, 2 absolute, 3 absolute+X, 4 absolute+Y, 5 (zero page+X) pointer, 6 (zero page) pointer+Y.
- R3: Zero page takes 3 cycles: pc, pc+1, then the access at 00:op.
- R4: Zero page+X takes 4 cycles. It does a dummy read at 00:op and then accesses 00:((op+X) mod 256), so C0 with X=80 reaches 0040.
- R5: Absolute takes 4 cycles: pc, pc+1 (low byte), pc+2 (high byte), then the access at high:low.
- R6: An absolute indexed load reads high:((low+I) mod 256) in cycle 4. That read is final when the sum does not carry (4 cycles). On a carry a fifth read at (high+1):((low+I) mod 256) is the final one.
- R7: An absolute indexed store always takes 5 cycles: a read at high:((low+I) mod 256), then a write at the carry-corrected address.
- R8: The indexed pointer mode takes 6 cycles: a dummy read at 00:op, then the pointer low byte at 00:p with p=(op+X) mod 256, then the high byte at 00:((p+1) mod 256), then the access.
- R9: The pointer-then-Y mode reads the pointer bytes at 00:op and 00:((op+1) mod 256), then follows the rules of R6 for loads (5 or 6 cycles) and of R7 for stores (always 6 cycles).
- R10: After a load's final read, `ld_valid` is high for exactly the next cycle and `ld_data` holds the byte read in that final cycle.
- R11: A store's only write cycle is its last one, and `bus_wdata` then carries the store data latched at the start.
- R12: `done` is 1 only in the final cycle of an instruction and while idle. A start given in a final cycle puts the next instruction's opcode read on the bus in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (taken when done=1) |
| mode | input | 3 | Addressing-mode code |
| is_store | input | 1 | 1 = store, 0 = load |
| pc | input | 2*DW | Address of the opcode byte |
| idx_x | input | DW | X index |
| idx_y | input | DW | Y index |
| st_data | input | DW | Byte to store |
| bus_rdata | input | DW | Data returned for the current bus address |
| bus_addr | output | 2*DW | Bus address, registered |
| bus_rw | output | 1 | 1 = read, 0 = write, registered |
| bus_wdata | output | DW | Write data |
| done | output | 1 | Final cycle or idle; start accepted |
| ld_valid | output | 1 | Load result valid pulse |
| ld_data | output | DW | Loaded byte |

## Verification
Every mode is driven with operand and pointer bytes chosen so that the index sum either stays in its page or carries. Both outcomes are tried for loads and for stores, which tells apart the load shortcut from the fixed store length. Directed cases place the zero-page base or pointer at FF to expose any carry leaking out of page zero. Random runs scramble the inputs and pulse `start` while an instruction is busy, which separates latched values from live ones. Some random runs also chain instructions back to back, which shows whether `done` lets the next opcode cycle follow the final access with no gap.

// File: rtl/lsseq_pkg.sv
package lsseq_pkg;
  typedef enum logic [2:0] {
    AM_ZP  = 3'd0,
    AM_ZPX = 3'd1,
    AM_ABS = 3'd2,
    AM_ABX = 3'd3,
    AM_ABY = 3'd4,
    AM_IZX = 3'd5,
    AM_IZY = 3'd6,
    AM_RSV = 3'd7
  } amode_t;

  typedef enum logic [3:0] {
    S_IDLE, S_OPC, S_OPR1, S_OPR2, S_ZDUM, S_PLO, S_PHI, S_FIX, S_FIN
  } step_t;
endpackage

// File: rtl/lsseq_idx_add.sv
module lsseq_idx_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry
);
  logic [W:0] full;
  assign full  = {1'b0, a} + {1'b0, b};
  assign sum   = full[W-1:0];
  assign carry = full[W];
endmodule

// File: rtl/lsseq_wrap_inc.sv
module lsseq_wrap_inc #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         inc,
  output logic [W-1:0] y
);
  assign y = a + {{(W-1){1'b0}}, inc};
endmodule

// File: rtl/lsseq_top.sv
module lsseq_top
  import lsseq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int MAX_CYC = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      mode,
  input  logic            is_store,
  input  logic [2*DW-1:0] pc,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  input  logic [DW-1:0]   st_data,
  input  logic [DW-1:0]   bus_rdata,
  output logic [2*DW-1:0] bus_addr,
  output logic            bus_rw,
  output logic [DW-1:0]   bus_wdata,
  output logic            done,
  output logic            ld_valid,
  output logic [DW-1:0]   ld_data
);
  localparam int AW = 2 * DW;
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [DW-1:0] ZPAGE = '0;

  step_t          st, nst;
  amode_t         mode_r;
  logic           store_r;
  logic [AW-1:0]  pc_r, naddr;
  logic [DW-1:0]  x_r, y_r, base_r, lo_r, hi_r;
  logic [DW-1:0]  nbase, nlo, nhi;
  logic           carry_r, ncarry, nrw;
  logic [CW-1:0]  cyc;

  logic [DW-1:0]  add_a, add_b, add_sum, base_inc, hi_fix;
  logic           add_c, launch, use_y;

  // one shared index adder: base+X in the dummy cycle, low byte+index elsewhere
  assign use_y = (mode_r == AM_ABY) || (mode_r == AM_IZY);
  assign add_a = (st == S_ZDUM) ? base_r : lo_r;
  assign add_b = (st == S_ZDUM) ? x_r : (use_y ? y_r : x_r);

  lsseq_idx_add #(.W(DW)) u_add (.a(add_a), .b(add_b), .sum(add_sum), .carry(add_c));
  lsseq_wrap_inc #(.W(DW)) u_pinc (.a(base_r), .inc(1'b1), .y(base_inc));
  lsseq_wrap_inc #(.W(DW)) u_hfix (.a(hi_r), .inc(carry_r), .y(hi_fix));

  assign launch = done && start;

  always_comb begin
    nst    = st;
    naddr  = bus_addr;
    nrw    = 1'b1;
    nbase  = base_r;
    nlo    = lo_r;
    nhi    = hi_r;
    ncarry = carry_r;
    case (st)
      S_OPC: begin
        nst   = S_OPR1;
        naddr = pc_r + AW'(1);
      end
      S_OPR1: begin
        case (mode_r)
          AM_ZP: begin
            nst   = S_FIN;
            naddr = {ZPAGE, bus_rdata};
            nrw   = ~store_r;
          end
          AM_ZPX, AM_IZX: begin
            nst   = S_ZDUM;
            naddr = {ZPAGE, bus_rdata};
            nbase = bus_rdata;
          end
          AM_IZY: begin
            nst   = S_PLO;
            naddr = {ZPAGE, bus_rdata};
            nbase = bus_rdata;
          end
          default: begin
            nst   = S_OPR2;
            naddr = pc_r + AW'(2);
            nlo   = bus_rdata;
          end
        endcase
      end
      S_OPR2: begin
        nhi = bus_rdata;
        if (mode_r == AM_ABX || mode_r == AM_ABY) begin
          nlo    = add_sum;
          ncarry = add_c;
          naddr  = {bus_rdata, add_sum};
          nst    = (add_c || store_r) ? S_FIX : S_FIN;
        end else begin
          nst   = S_FIN;
          naddr = {bus_rdata, lo_r};
          nrw   = ~store_r;
        end
      end
      S_ZDUM: begin
        naddr = {ZPAGE, add_sum};
        if (mode_r == AM_IZX) begin
          nst   = S_PLO;
          nbase = add_sum;
        end else begin
          nst = S_FIN;
          nrw = ~store_r;
        end
      end
      S_PLO: begin
        nlo   = bus_rdata;
        nst   = S_PHI;
        naddr = {ZPAGE, base_inc};
      end
      S_PHI: begin
        nhi = bus_rdata;
        if (mode_r == AM_IZX) begin
          nst   = S_FIN;
          naddr = {bus_rdata, lo_r};
          nrw   = ~store_r;
        end else begin
          nlo    = add_sum;
          ncarry = add_c;
          naddr  = {bus_rdata, add_sum};
          nst    = (add_c || store_r) ? S_FIX : S_FIN;
        end
      end
      S_FIX: begin
        nst   = S_FIN;
        naddr = {hi_fix, lo_r};
        nrw   = ~store_r;
      end
      S_FIN:   nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mode_r    <= AM_ZP;
      store_r   <= 1'b0;
      pc_r      <= '0;
      x_r       <= '0;
      y_r       <= '0;
      base_r    <= '0;
      lo_r      <= '0;
      hi_r      <= '0;
      carry_r   <= 1'b0;
      cyc       <= '0;
      bus_addr  <= '0;
      bus_rw    <= 1'b1;
      bus_wdata <= '0;
      done      <= 1'b1;
      ld_valid  <= 1'b0;
      ld_data   <= '0;
    end else begin
      base_r  <= nbase;
      lo_r    <= nlo;
      hi_r    <= nhi;
      carry_r <= ncarry;
      ld_valid <= (st == S_FIN) && !store_r;
      if (st == S_FIN && !store_r) ld_data <= bus_rdata;
      if (launch) begin
        st        <= S_OPC;
        bus_addr  <= pc;
        bus_rw    <= 1'b1;
        mode_r    <= amode_t'(mode);
        store_r   <= is_store;
        pc_r      <= pc;
        x_r       <= idx_x;
        y_r       <= idx_y;
        bus_wdata <= st_data;
        done      <= 1'b0;
        cyc       <= CW'(1);
      end else begin
        st       <= nst;
        bus_addr <= naddr;
        bus_rw   <= nrw;
        done     <= (nst == S_FIN) || (nst == S_IDLE);
        cyc      <= (nst == S_IDLE) ? '0 : cyc + CW'(1);
      end
    end
  end

  // assertions
  p_cyc_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cyc <= CW'(MAX_CYC));
  p_start_gated_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_OPC) |-> ($past(done) && $past(start)));
  p_zp_len_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIN && mode_r == AM_ZP) |-> cyc == CW'(3));
  p_zpx_len_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIN && mode_r == AM_ZPX) |-> cyc == CW'(4));
  p_abs_len_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIN && mode_r == AM_ABS) |-> cyc == CW'(4));
  p_fix_low_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIN && $past(st) == S_FIX) |-> bus_addr[DW-1:0] == $past(bus_addr[DW-1:0]));
  p_izx_len_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIN && mode_r == AM_IZX) |-> cyc == CW'(6));
  p_ptr_zpage_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_ZDUM || st == S_PLO || st == S_PHI) |-> bus_addr[AW-1:DW] == ZPAGE);
  p_ldv_after_load_r10: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> ($past(st) == S_FIN && !$past(store_r)));
  p_write_then_read_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rw |=> bus_rw);
  p_done_states_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (st == S_FIN || st == S_IDLE));
endmodule

// File: tb/lsseq_top_tb_top.sv
module lsseq_top_tb_top;
  localparam int DW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic        is_store = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  idx_x = '0, idx_y = '0, st_data = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr;
  logic        bus_rw, done, ld_valid;
  logic [7:0]  bus_wdata, ld_data;

  always #5 clk = ~clk;

  lsseq_top #(.DW(DW), .MAX_CYC(6)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .is_store(is_store),
    .pc(pc), .idx_x(idx_x), .idx_y(idx_y), .st_data(st_data),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_wdata(bus_wdata), .done(done), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // bench memory: zero page array, operand bytes at pc+1/pc+2, hash elsewhere
  logic [7:0]  zp_mem [0:255];
  logic [15:0] cur_pc = 16'h0200;
  logic [7:0]  op1 = '0, op2 = '0;

  function automatic logic [7:0] memf(input logic [15:0] a);
    if (a == cur_pc + 16'd1) return op1;
    if (a == cur_pc + 16'd2) return op2;
    if (a[15:8] == 8'h00) return zp_mem[a[7:0]];
    return (a[7:0] * 8'd7) ^ (a[15:8] * 8'd13) ^ 8'h5A;
  endfunction

  always_comb bus_rdata = memf(bus_addr);

  int n_chk = 0, n_bad = 0;
  logic [15:0] e_addr [0:7];
  logic        e_rw   [0:7];
  int          e_n;
  logic [7:0]  e_ld;
  bit          pend_ld = 1'b0;
  logic [7:0]  pend_val = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag(input logic [2:0] m, input logic s);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return s ? "R7" : "R6";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic push(input logic [15:0] a);
    e_addr[e_n] = a;
    e_rw[e_n]   = 1'b1;
    e_n++;
  endtask

  // reference trace from the requirements
  task automatic build_exp(input logic [2:0] m, input logic s, input logic [15:0] p,
                           input logic [7:0] x, input logic [7:0] y);
    logic [7:0] b, q, q1, lo, hi, i;
    logic [8:0] s9;
    e_n = 0;
    push(p);
    push(p + 16'd1);
    b = memf(p + 16'd1);
    case (m)
      3'd0: push({8'h00, b});
      3'd1: begin q = b + x; push({8'h00, b}); push({8'h00, q}); end
      3'd2: begin push(p + 16'd2); push({op2, op1}); end
      3'd3, 3'd4: begin
        i = (m == 3'd3) ? x : y;
        push(p + 16'd2);
        s9 = {1'b0, op1} + {1'b0, i};
        push({op2, s9[7:0]});
        if (s9[8] || s) push({op2 + {7'd0, s9[8]}, s9[7:0]});
      end
      3'd5: begin
        q = b + x; q1 = q + 8'd1;
        lo = zp_mem[q]; hi = zp_mem[q1];
        push({8'h00, b}); push({8'h00, q}); push({8'h00, q1}); push({hi, lo});
      end
      default: begin
        q1 = b + 8'd1;
        lo = zp_mem[b]; hi = zp_mem[q1];
        push({8'h00, b}); push({8'h00, q1});
        s9 = {1'b0, lo} + {1'b0, y};
        push({hi, s9[7:0]});
        if (s9[8] || s) push({hi + {7'd0, s9[8]}, s9[7:0]});
      end
    endcase
    e_rw[e_n-1] = !s;
    e_ld = memf(e_addr[e_n-1]);
  endtask

  // called at a negedge where done is high; leaves at the negedge of the final cycle
  task automatic issue(input logic [2:0] m, input logic s, input logic [15:0] p,
                       input logic [7:0] x, input logic [7:0] y, input logic [7:0] d,
                       input logic [7:0] o1, input logic [7:0] o2, input bit noise);
    string t;
    chk(done == 1'b1, "R12 ready before start", {31'd0, done}, 32'd1);
    cur_pc = p; op1 = o1; op2 = o2;
    build_exp(m, s, p, x, y);
    t = tag(m, s);
    mode = m; is_store = s; pc = p; idx_x = x; idx_y = y; st_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (noise) begin
      mode = 3'($urandom); is_store = 1'($urandom); pc = 16'($urandom);
      idx_x = 8'($urandom); idx_y = 8'($urandom); st_data = 8'($urandom);
    end
    for (int k = 0; k < e_n; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0) begin
        // R2: opcode read at the latched pc
        chk(bus_addr == e_addr[0] && bus_rw, "R2 opcode cycle", {15'd0, bus_rw, bus_addr}, {15'd0, 1'b1, e_addr[0]});
        if (pend_ld)
          chk(ld_valid && ld_data == pend_val, "R10 chained load result", {23'd0, ld_valid, ld_data}, {23'd0, 1'b1, pend_val});
        pend_ld = 1'b0;
      end else begin
        chk(bus_addr == e_addr[k] && bus_rw == e_rw[k], t, {15'd0, bus_rw, bus_addr}, {15'd0, e_rw[k], e_addr[k]});
      end
      if (!bus_rw) chk(bus_wdata == d, "R11 write data", {24'd0, bus_wdata}, {24'd0, d});
      chk(done == (k == e_n - 1), "R12 done timing", {31'd0, done}, {31'd0, k == e_n - 1});
      if (noise && k < e_n - 1) start = 1'($urandom);
      else start = 1'b0;
    end
    pend_ld  = !s;
    pend_val = e_ld;
  endtask

  task automatic idle_end();
    @(negedge clk);
    if (pend_ld)
      chk(ld_valid && ld_data == pend_val, "R10 load result", {23'd0, ld_valid, ld_data}, {23'd0, 1'b1, pend_val});
    else
      chk(ld_valid == 1'b0, "R10 no result after store", {31'd0, ld_valid}, 32'd0);
    chk(done == 1'b1, "R12 idle done", {31'd0, done}, 32'd1);
    pend_ld = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int a = 0; a < 256; a++) zp_mem[a] = 8'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(done && bus_rw && bus_addr == 16'h0000 && !ld_valid, "R1 reset state",
        {14'd0, done, bus_rw, bus_addr}, {14'd0, 1'b1, 1'b1, 16'h0000});

    // directed corner cases
    issue(3'd0, 1'b0, 16'h0300, 8'h00, 8'h00, 8'h00, 8'h37, 8'h00, 1'b0); idle_end();  // R3
    issue(3'd1, 1'b1, 16'h0310, 8'h80, 8'h00, 8'hA5, 8'hC0, 8'h00, 1'b0); idle_end();  // R4 wrap to 0040
    issue(3'd2, 1'b1, 16'h0320, 8'h00, 8'h00, 8'h3C, 8'h34, 8'h12, 1'b0); idle_end();  // R5
    issue(3'd3, 1'b0, 16'h0330, 8'h20, 8'h00, 8'h00, 8'hF0, 8'h45, 1'b0); idle_end();  // R6 carry
    issue(3'd3, 1'b0, 16'h0340, 8'h05, 8'h00, 8'h00, 8'h10, 8'h45, 1'b0); idle_end();  // R6 no carry
    issue(3'd4, 1'b1, 16'h0350, 8'h00, 8'h05, 8'h99, 8'h10, 8'h45, 1'b0); idle_end();  // R7 no carry
    issue(3'd3, 1'b1, 16'h0360, 8'hFF, 8'h00, 8'h66, 8'h02, 8'h45, 1'b0); idle_end();  // R7 carry
    zp_mem[8'hFF] = 8'h21; zp_mem[8'h00] = 8'h43;
    issue(3'd5, 1'b0, 16'h0370, 8'h80, 8'h00, 8'h00, 8'h7F, 8'h00, 1'b0); idle_end();  // R8 pointer at FF
    zp_mem[8'hFF] = 8'h20; zp_mem[8'h00] = 8'h55;
    issue(3'd6, 1'b0, 16'h0380, 8'h00, 8'h03, 8'h00, 8'hFF, 8'h00, 1'b0); idle_end();  // R9 no carry, wrap
    zp_mem[8'h40] = 8'hF8; zp_mem[8'h41] = 8'h33;
    issue(3'd6, 1'b0, 16'h0390, 8'h00, 8'h10, 8'h00, 8'h40, 8'h00, 1'b0); idle_end();  // R9 carry
    issue(3'd6, 1'b1, 16'h03A0, 8'h00, 8'h01, 8'h77, 8'h40, 8'h00, 1'b0); idle_end();  // R9 store no carry
    // R12 back to back: load then store with no gap
    issue(3'd0, 1'b0, 16'h0400, 8'h00, 8'h00, 8'h00, 8'h12, 8'h00, 1'b0);
    issue(3'd2, 1'b1, 16'h0500, 8'h00, 8'h00, 8'hE1, 8'h00, 8'h60, 1'b0); idle_end();

    // random runs with scrambled inputs and spurious starts (R2)
    for (int r = 0; r < 300; r++) begin
      logic [15:0] p;
      bit chain;
      p = 16'h0200 + 16'($urandom % 32'h7C00);
      if (p[7:0] > 8'hF0) p[7:0] = 8'h10;
      if (r % 16 == 0) for (int a = 0; a < 256; a++) zp_mem[a] = 8'($urandom);
      issue(3'($urandom % 7), 1'($urandom), p, 8'($urandom), 8'($urandom), 8'($urandom),
            8'($urandom), 8'($urandom), 1'b1);
      chain = (($urandom % 2) == 1) && (e_addr[e_n-1][15:8] != 8'h7F) && (e_addr[e_n-1][15:8] != 8'h80)
              && (e_addr[e_n-1][15:8] < 8'h02 || e_addr[e_n-1][15:8] > 8'h81);
      if (chain)
        issue(3'($urandom % 7), 1'($urandom), 16'h8010, 8'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), 1'b0);
      idle_end();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule